// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block runs a complete erase on a serial NOR flash over a single-data-line SPI link. The host picks one of three erase sizes (whole chip, sector or subsector), supplies a target address and selects 24-bit or 32-bit addressing, then pulses a start strobe. The block handles the whole device conversation without further help. It sends a write-enable command in its own chip-select frame and reads the status register once to confirm that the write-enable latch took. It then sends the erase command with its address, if the erase size uses one. After that it reads the status register again and again, in separate frames with an idle gap between them, until the write-in-progress flag drops.

The result is a one-cycle done pulse and an error flag. The error flag is set when the latch check fails, when the status polling budget runs out, or when the erase-size code is not a valid one. A busy output tells the host that a request is being served; a start strobe seen while busy has no effect.

Top module: `flash_erase_ctrl`

## Requirements
- R1: While reset is held and after it is released, chip select is high, the serial clock is low, and done, busy and error are all 0.
- R2: The first frame after an accepted start is exactly 8 clocks long and carries the write-enable byte 06h, and chip select goes high after it.
- R3: The second frame carries the status-read byte 05h and is followed by 8 more clocks that read the status byte. If status bit 1 (write-enable latch) is 0, the block finishes with error 1 and sends no erase frame.
- R4: The erase-size code selects the erase opcode: 0 gives C7h with no address (an 8-clock frame), 1 gives D8h and 2 gives 20h, each followed by the address MSB first.
- R5: With the address-mode input at 0, only address bits 23..0 are sent (24 bits). With it at 1, all 32 bits are sent.
- R6: After the erase frame, the block repeats 16-clock status-read frames (05h, then 8 read clocks) until status bit 0 (write in progress) reads 0. It then pulses done with error 0.
- R7: Between any two frames, chip select stays high for at least GAP_CYCLES clock cycles.
- R8: If MAX_POLLS status reads after the erase all return bit 0 set, the block stops polling after exactly that many reads and pulses done with error 1.
- R9: The erase-size code 3 is rejected. Done and error are both 1 one cycle after the start, and no frame is sent.
- R10: The serial clock is low whenever chip select is high. Each clock high phase lasts HALF_DIV cycles. MOSI changes only when the serial clock falls or chip select falls. MISO is sampled at the rising edge, MSB first.
- R11: A start seen while busy is ignored. Done is a one-cycle pulse and busy drops in the same cycle. Error keeps its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| erase_kind_i | input | 2 | Erase size: 0 chip, 1 sector, 2 subsector, 3 invalid |
| addr_i | input | 32 | Any address inside the target region |
| addr4_i | input | 1 | 1 selects 32-bit addressing, 0 selects 24-bit |
| busy_o | output | 1 | High while a request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error result, valid from the done pulse |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench connects a behavioural flash that decodes every frame, tracks its own latch and busy flags, and answers status reads. It checks the two edges of the polling budget: a flash that stays busy for one read fewer than the limit must end cleanly, and one that stays busy for exactly the limit must time out. An off-by-one poll counter fails one of these two. It drives a 3-byte sector erase with nonzero upper address bits, so a design that sends the wrong width or leaks the top byte shows up in the frame contents. It also covers a flash that refuses write enable, where a design that skips the latch check would send an erase. Finally, it sends a second start in the middle of a run; a design that accepts it would corrupt the frame sequence.

// File: rtl/flash_erase_pkg.sv
// Package: shared opcodes, erase-size codes and sequencer phases for the
// flash erase sequencer. Assumes a single-line SPI flash with standard
// command bytes and a 40-bit maximum outbound frame (opcode + 32-bit address).
package flash_erase_pkg;

    localparam int FRAME_W = 40;   // widest outbound payload in bits
    localparam int NBITS_W = 6;    // width of a frame bit count

    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_RDSR     = 8'h05;
    localparam logic [7:0] OP_CHIP     = 8'hC7;
    localparam logic [7:0] OP_SECTOR   = 8'hD8;
    localparam logic [7:0] OP_SUBSECT  = 8'h20;

    localparam int ST_BUSY_BIT  = 0;   // write in progress
    localparam int ST_LATCH_BIT = 1;   // write enable latch

    typedef enum logic [1:0] {
        KIND_CHIP    = 2'd0,
        KIND_SECTOR  = 2'd1,
        KIND_SUBSECT = 2'd2,
        KIND_INVALID = 2'd3
    } erase_kind_t;

    typedef enum logic [1:0] {
        PH_WREN  = 2'd0,
        PH_CHECK = 2'd1,
        PH_ERASE = 2'd2,
        PH_POLL  = 2'd3
    } phase_t;

endpackage

// File: rtl/flash_spi_frame.sv
// Module: flash_spi_frame
// Shifts one chip-select frame of NBITS clocks in SPI mode 0. The payload is
// left-aligned in tx_i; once the payload runs out, MOSI is 0. Every bit
// received on MISO is shifted into rx_o, so after a frame rx_o holds the
// last 8 bits read. Assumes req_i comes only while the engine is idle and
// that nbits_i is at least 1.
module flash_spi_frame
    import flash_erase_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [FRAME_W-1:0] tx_i,
    input  logic [NBITS_W-1:0] nbits_i,
    input  logic               miso_i,
    output logic               cs_n_o,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               done_o,
    output logic [7:0]         rx_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic               active;
    logic [FRAME_W-1:0] sreg;
    logic [NBITS_W-1:0] left;
    logic [DW-1:0]      div;

    // Frame engine: chip select, clock phases, bit shifting and MISO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cs_n_o <= 1'b1;
            sck_o  <= 1'b0;
            mosi_o <= 1'b0;
            done_o <= 1'b0;
            rx_o   <= '0;
            sreg   <= '0;
            left   <= '0;
            div    <= '0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (req_i) begin
                    active <= 1'b1;
                    cs_n_o <= 1'b0;
                    sck_o  <= 1'b0;
                    mosi_o <= tx_i[FRAME_W-1];
                    sreg   <= tx_i << 1;
                    left   <= nbits_i;
                    div    <= '0;
                end
            end else if (div == DW'(HALF_DIV - 1)) begin
                div <= '0;
                if (!sck_o) begin
                    sck_o <= 1'b1;
                    rx_o  <= {rx_o[6:0], miso_i};
                end else begin
                    sck_o <= 1'b0;
                    if (left == NBITS_W'(1)) begin
                        active <= 1'b0;
                        cs_n_o <= 1'b1;
                        mosi_o <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        left   <= left - 1'b1;
                        mosi_o <= sreg[FRAME_W-1];
                        sreg   <= sreg << 1;
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq
// Command sequencer: write enable, latch check, erase, then status polling
// until the busy bit clears or the poll budget runs out. Holds chip select
// high for GAP_CYCLES between frames. Assumes GAP_CYCLES >= 1, MAX_POLLS >= 1.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int GAP_CYCLES = 4,
    parameter int MAX_POLLS  = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         kind_i,
    input  logic [31:0]        addr_i,
    input  logic               addr4_i,
    input  logic               eng_done_i,
    input  logic [7:0]         eng_rx_i,
    output logic               req_o,
    output logic [FRAME_W-1:0] tx_o,
    output logic [NBITS_W-1:0] nbits_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} state_t;

    state_t             state;
    phase_t             phase;
    erase_kind_t        kind_q;
    logic [31:0]        addr_q;
    logic               a4_q;
    logic [GW-1:0]      gap_cnt;
    logic [PW-1:0]      poll_cnt;
    logic [FRAME_W-1:0] frm_tx;
    logic [NBITS_W-1:0] frm_bits;
    logic [7:0]         erase_op;

    // Opcode for the latched erase size.
    always_comb begin
        case (kind_q)
            KIND_SECTOR:  erase_op = OP_SECTOR;
            KIND_SUBSECT: erase_op = OP_SUBSECT;
            default:      erase_op = OP_CHIP;
        endcase
    end

    // Payload and length of the frame belonging to the current phase.
    always_comb begin
        frm_tx   = {OP_RDSR, 32'h0};
        frm_bits = NBITS_W'(16);
        case (phase)
            PH_WREN: begin
                frm_tx   = {OP_WREN, 32'h0};
                frm_bits = NBITS_W'(8);
            end
            PH_ERASE: begin
                if (kind_q == KIND_CHIP) begin
                    frm_tx   = {OP_CHIP, 32'h0};
                    frm_bits = NBITS_W'(8);
                end else if (a4_q) begin
                    frm_tx   = {erase_op, addr_q};
                    frm_bits = NBITS_W'(40);
                end else begin
                    frm_tx   = {erase_op, addr_q[23:0], 8'h0};
                    frm_bits = NBITS_W'(32);
                end
            end
            default: ;
        endcase
    end

    // Sequencer: accepts a request, walks the phases and reports the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_WREN;
            kind_q   <= KIND_CHIP;
            addr_q   <= '0;
            a4_q     <= 1'b0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            req_o    <= 1'b0;
            tx_o     <= '0;
            nbits_o  <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            req_o  <= 1'b0;
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        kind_q <= erase_kind_t'(kind_i);
                        addr_q <= addr_i;
                        a4_q   <= addr4_i;
                        if (erase_kind_t'(kind_i) == KIND_INVALID) begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else begin
                            err_o   <= 1'b0;
                            busy_o  <= 1'b1;
                            phase   <= PH_WREN;
                            tx_o    <= {OP_WREN, 32'h0};
                            nbits_o <= NBITS_W'(8);
                            req_o   <= 1'b1;
                            state   <= ST_SHIFT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (eng_done_i) begin
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                        case (phase)
                            PH_WREN: phase <= PH_CHECK;
                            PH_CHECK: begin
                                if (eng_rx_i[ST_LATCH_BIT]) begin
                                    phase <= PH_ERASE;
                                end else begin
                                    state  <= ST_IDLE;
                                    busy_o <= 1'b0;
                                    done_o <= 1'b1;
                                    err_o  <= 1'b1;
                                end
                            end
                            PH_ERASE: begin
                                phase    <= PH_POLL;
                                poll_cnt <= '0;
                            end
                            default: begin
                                if (!eng_rx_i[ST_BUSY_BIT] ||
                                    poll_cnt == PW'(MAX_POLLS - 1)) begin
                                    state  <= ST_IDLE;
                                    busy_o <= 1'b0;
                                    done_o <= 1'b1;
                                    err_o  <= eng_rx_i[ST_BUSY_BIT];
                                end else begin
                                    poll_cnt <= poll_cnt + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
                        req_o   <= 1'b1;
                        tx_o    <= frm_tx;
                        nbits_o <= frm_bits;
                        state   <= ST_SHIFT;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
// Module: flash_erase_ctrl (top)
// Serial flash erase sequencer: joins the command sequencer to the SPI frame
// engine. Assumes a flash that answers the status-read command with one
// status byte (bit 0 busy, bit 1 write-enable latch).
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int GAP_CYCLES = 4,
    parameter int MAX_POLLS  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  erase_kind_i,
    input  logic [31:0] addr_i,
    input  logic        addr4_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic        spi_cs_n_o,
    output logic        spi_sck_o,
    output logic        spi_mosi_o,
    input  logic        spi_miso_i
);
    logic               req;
    logic [FRAME_W-1:0] tx;
    logic [NBITS_W-1:0] nbits;
    logic               eng_done;
    logic [7:0]         eng_rx;

    flash_erase_seq #(
        .GAP_CYCLES (GAP_CYCLES),
        .MAX_POLLS  (MAX_POLLS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .kind_i     (erase_kind_i),
        .addr_i     (addr_i),
        .addr4_i    (addr4_i),
        .eng_done_i (eng_done),
        .eng_rx_i   (eng_rx),
        .req_o      (req),
        .tx_o       (tx),
        .nbits_o    (nbits),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    flash_spi_frame #(
        .HALF_DIV (HALF_DIV)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .tx_i    (tx),
        .nbits_i (nbits),
        .miso_i  (spi_miso_i),
        .cs_n_o  (spi_cs_n_o),
        .sck_o   (spi_sck_o),
        .mosi_o  (spi_mosi_o),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
// Module: flash_erase_ctrl_chk
// Protocol checker bound to flash_erase_ctrl; observes its ports only.
module flash_erase_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] erase_kind_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       spi_cs_n_o,
    input logic       spi_sck_o,
    input logic       spi_mosi_o
);
    // R10
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o);

    // R10
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R7
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> spi_cs_n_o);

    // R9
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o && erase_kind_i == 2'd3) |=> (done_o && err_o));

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .erase_kind_i (erase_kind_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .spi_cs_n_o   (spi_cs_n_o),
    .spi_sck_o    (spi_sck_o),
    .spi_mosi_o   (spi_mosi_o)
);

// File: tb/flash_erase_ctrl_bench.sv
// Bench: behavioural flash model plus per-clock protocol monitor.
module flash_erase_ctrl_bench;
    localparam int HALF = 2;
    localparam int GAP  = 3;
    localparam int MAXP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [31:0] addr = 32'h0;
    logic        a4 = 1'b0;
    logic        busy, done, err, cs_n, sck, mosi, miso;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flash_erase_ctrl #(.HALF_DIV(HALF), .GAP_CYCLES(GAP), .MAX_POLLS(MAXP)) u_flash_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .erase_kind_i(kind),
        .addr_i(addr), .addr4_i(a4), .busy_o(busy), .done_o(done), .err_o(err),
        .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural flash ----------------
    bit          in_fr = 1'b0;
    int          fr_n = 0;
    logic [39:0] fr_sh = '0;
    logic [7:0]  fr_op = '0;
    logic [7:0]  snap = '0;
    bit          m_wel = 1'b0, m_wip = 1'b0, m_wren_ok = 1'b1;
    int          m_left = 0, m_load = 0;
    logic [39:0] fdata[$];
    int          fbits[$];

    assign miso = (in_fr && fr_n >= 8 && fr_n < 16 && fr_op == 8'h05) ? snap[15 - fr_n] : 1'b0;

    always @(negedge cs_n) begin
        in_fr = 1'b1; fr_n = 0; fr_sh = '0; fr_op = '0;
    end

    always @(posedge sck) if (in_fr) begin
        fr_sh = {fr_sh[38:0], mosi};
        fr_n++;
        if (fr_n == 8) begin
            fr_op = fr_sh[7:0];
            snap  = {6'b0, m_wel, m_wip};
        end
    end

    always @(posedge cs_n) if (in_fr) begin
        in_fr = 1'b0;
        fdata.push_back(fr_sh);
        fbits.push_back(fr_n);
        if (fr_op == 8'h06 && fr_n == 8 && m_wren_ok) m_wel = 1'b1;
        else if (m_wel && ((fr_op == 8'hC7 && fr_n == 8) ||
                 ((fr_op == 8'hD8 || fr_op == 8'h20) && fr_n >= 32))) begin
            m_wel = 1'b0; m_wip = (m_load > 0); m_left = m_load;
        end else if (fr_op == 8'h05 && m_wip) begin
            if (m_left <= 1) m_wip = 1'b0; else m_left--;
        end
    end

    // ---------------- per-clock monitor ----------------
    logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
    int   hi_cnt = 0, gap_len = 0;
    bit   seen = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (cs_n && sck) chk(1'b0, "R10", "sck high while deselected", 1, 0);
        if (mosi !== p_mosi)
            chk((p_sck && !sck) || (p_cs && !cs_n), "R10", "mosi change off falling edge", mosi, p_mosi);
        if (sck) hi_cnt++;
        else if (p_sck) begin
            chk(hi_cnt == HALF, "R10", "sck high length", hi_cnt, HALF);
            hi_cnt = 0;
        end
        if (cs_n) gap_len++;
        else if (p_cs) begin
            if (seen) chk(gap_len >= GAP, "R7", "cs high gap", gap_len, GAP);
            seen = 1'b1;
            gap_len = 0;
        end
        p_cs = cs_n; p_sck = sck; p_mosi = mosi;
    end

    // ---------------- scenario runner ----------------
    task automatic run_case(input logic [1:0] k, input logic [31:0] ad, input bit w4,
                            input bit wok, input int busyk, input bit inject, input string tag);
        logic [39:0] ed[$];
        int          eb[$];
        bit          exp_err;
        int          polls, wait_n;
        logic [7:0]  op;
        fdata.delete(); fbits.delete();
        m_wel = 1'b0; m_wip = 1'b0; m_wren_ok = wok; m_load = busyk;
        exp_err = 1'b0;
        if (k == 2'd3) exp_err = 1'b1;
        else begin
            ed.push_back(40'h06); eb.push_back(8);
            ed.push_back(40'h0500); eb.push_back(16);
            if (!wok) exp_err = 1'b1;
            else begin
                op = (k == 2'd1) ? 8'hD8 : 8'h20;
                if (k == 2'd0) begin ed.push_back(40'hC7); eb.push_back(8); end
                else if (w4) begin ed.push_back({op, ad}); eb.push_back(40); end
                else begin ed.push_back({8'h0, op, ad[23:0]}); eb.push_back(32); end
                polls = (busyk + 1 <= MAXP) ? busyk + 1 : MAXP;
                exp_err = (busyk + 1 > MAXP);
                for (int i = 0; i < polls; i++) begin ed.push_back(40'h0500); eb.push_back(16); end
            end
        end
        @(negedge clk);
        kind = k; addr = ad; a4 = w4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (k != 2'd3) chk(busy && !err && !done, "R11", {tag, " busy set, err cleared on start"},
                           {busy, err}, 2'b10);
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
            if (inject && wait_n == 20) begin
                kind = 2'd3; start = 1'b1;
                @(negedge clk);
                start = 1'b0; kind = k;
            end
        end
        chk(done, "R11", {tag, " done seen"}, done, 1);
        chk(err == exp_err, (k == 2'd3) ? "R9" : (busyk + 1 > MAXP) ? "R8" : (!wok) ? "R3" : "R6",
            {tag, " error result"}, err, exp_err);
        chk(!busy, "R11", {tag, " busy low with done"}, busy, 0);
        chk(fdata.size() == ed.size(), "R6", {tag, " frame count"}, fdata.size(), ed.size());
        for (int i = 0; i < ed.size() && i < fdata.size(); i++) begin
            chk(fbits[i] == eb[i], (i == 0) ? "R2" : (i == 2) ? "R5" : "R3",
                {tag, " frame length"}, fbits[i], eb[i]);
            chk(fdata[i] == ed[i], (i == 0) ? "R2" : (i == 2) ? "R4" : "R6",
                {tag, " frame contents"}, fdata[i], ed[i]);
        end
        @(negedge clk);
        chk(!done, "R11", {tag, " done is one cycle"}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sck && !done && !busy && !err, "R1", "state in reset",
            {cs_n, sck, done, busy, err}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sck && !done && !busy && !err, "R1", "state after reset",
            {cs_n, sck, done, busy, err}, 5'b10000);

        run_case(2'd0, 32'h0000_0000, 1'b0, 1'b1, 3, 1'b0, "R4 chip erase");
        run_case(2'd1, 32'h12AB_CDEF, 1'b0, 1'b1, 1, 1'b0, "R5 sector 24-bit");
        run_case(2'd2, 32'h89AB_CDEF, 1'b1, 1'b1, 0, 1'b0, "R5 subsector 32-bit");
        run_case(2'd1, 32'hF000_0F0F, 1'b1, 1'b1, MAXP - 1, 1'b0, "R6 last poll clears");
        run_case(2'd2, 32'h0001_2345, 1'b0, 1'b1, MAXP, 1'b0, "R8 poll timeout");
        repeat (10) @(negedge clk);
        chk(err && !busy && !done, "R11", "error held while idle", {err, busy, done}, 3'b100);
        run_case(2'd1, 32'h0000_1000, 1'b0, 1'b0, 2, 1'b0, "R3 latch refused");
        run_case(2'd3, 32'h0000_0000, 1'b0, 1'b1, 0, 1'b0, "R9 invalid kind");
        run_case(2'd0, 32'h0000_0000, 1'b1, 1'b1, 2, 1'b1, "R11 start while busy");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule